// File: doc/BRIEF.md
# I2C Input Glitch Filter

This block sits between the pads of an I2C/SMBus master and its bit-level state machine. Each of the two bus lines, clock and data, passes through a two-stage synchronizer and then a qualifier. The qualifier changes its output level only after the synchronized input has held the new level for a programmed number of system clocks. Runt pulses shorter than that window never reach the master, so the master never counts them as clock edges or sees them as false stretching.

The window length comes from a 3-bit code that selects a non-linear set of lengths. A separate enable bit gates the code. While the enable is clear, or the code is zero, the lines pass straight through the synchronizers. Alongside each filtered level the block produces single-cycle rising and falling strobes. The clock-stretch logic uses the clock-line strobes. A change of code or enable is captured only while a line is idle, so a setting never alters a transition already being qualified.

Top module: `i2c_glitch_filter`

## Requirements
- R1: While reset is high, and in the first cycle after it, both filtered outputs are 1 and all four strobes are 0.
- R2: With the enable set, the code selects the qualification length N: code 0 means off, codes 1, 2, 3 and 4 give that many clocks, code 5 gives 8, code 6 gives 16 and code 7 gives 32.
- R3: A raw level that differs from the filtered output for fewer than N consecutive clocks never reaches the filtered output. Any return to the filtered level before N clocks restarts the count.
- R4: A raw change held for at least N clocks appears on the filtered output at the (N+2)th rising clock edge after the raw change. The two extra edges are the synchronizer.
- R5: With the enable clear, any code is ignored. Every pulse of one clock or longer passes with the latency of N=1.
- R6: With the enable set and code 0, the filter is off and behaves exactly as in R5.
- R7: A rising strobe (filtered 0 to 1) or a falling strobe (filtered 1 to 0) is high for exactly the one cycle in which that filtered output changes, and never at any other time.
- R8: The clock and data lines are qualified by independent counters. Activity on one line never changes the other line's outputs.
- R9: A code or enable change made while a transition is being counted leaves that transition's timing unchanged. A change made while the lines are idle never produces a filtered edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Clock line from the pad |
| sda_raw | input | 1 | Data line from the pad |
| flt_code | input | 3 | Qualification length code (R2) |
| flt_en | input | 1 | Filter enable; when clear, the code is ignored |
| scl_flt | output | 1 | Filtered clock line |
| sda_flt | output | 1 | Filtered data line |
| scl_rise | output | 1 | One-cycle strobe on a filtered clock rising edge |
| scl_fall | output | 1 | One-cycle strobe on a filtered clock falling edge |
| sda_rise | output | 1 | One-cycle strobe on a filtered data rising edge |
| sda_fall | output | 1 | One-cycle strobe on a filtered data falling edge |

## Verification
A wrong counter value or a stale latched length shows up as a filtered edge that arrives earlier or later than edge N+2, or as a runt that leaks through. The bench measures the edge index of every transition, so such a fault appears within at most 34 clocks of the stimulus. A strobe that is out of step with its level, or a false edge caused by a setting change, is visible on the very cycle it happens. Crosstalk between the two channels appears as movement on the idle line during a pulse on the other line.

// File: rtl/i2c_gf_pkg.sv
package i2c_gf_pkg;
    localparam int CODE_W  = 3;
    localparam int LEN_MAX = 32;
    localparam int LEN_W   = $clog2(LEN_MAX + 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } chan_out_t;

    // codes 0..4 are literal, above that a power of two
    function automatic len_t code_to_len(input code_t code);
        if (code <= code_t'(4))
            return len_t'(code);
        return len_t'(1) << (code - code_t'(2));
    endfunction
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gf_len_sel.sv
module gf_len_sel
    import i2c_gf_pkg::*;
(
    input  code_t code,
    input  logic  en,
    output len_t  req_len
);
    always_comb begin
        req_len = en ? code_to_len(code) : len_t'(0);
    end
endmodule

// File: rtl/gf_chan.sv
module gf_chan
    import i2c_gf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  len_t      req_len,
    output chan_out_t q
);
    logic lvl, rise, fall;
    len_t cnt, eff;
    logic done;

    // eff of 0 or 1 both mean one evaluation suffices
    always_comb begin
        done = (eff <= len_t'(1)) || (cnt >= eff - len_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl  <= 1'b1;
            cnt  <= '0;
            eff  <= '0;
            rise <= 1'b0;
            fall <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (din == lvl) begin
                cnt <= '0;
                eff <= req_len;       // settings captured only while idle
            end else if (done) begin
                lvl  <= din;
                cnt  <= '0;
                rise <= din;
                fall <= ~din;
            end else begin
                cnt <= cnt + len_t'(1);
            end
        end
    end

    assign q = '{lvl: lvl, rise: rise, fall: fall};
endmodule

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter
    import i2c_gf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_raw,
    input  logic              sda_raw,
    input  logic [CODE_W-1:0] flt_code,
    input  logic              flt_en,
    output logic              scl_flt,
    output logic              sda_flt,
    output logic              scl_rise,
    output logic              scl_fall,
    output logic              sda_rise,
    output logic              sda_fall
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_vec, sync_vec;
    len_t           req_len;
    chan_out_t      ch_q [NCH];
    logic           scl_sync, sda_sync;

    assign raw_vec = {sda_raw, scl_raw};

    gf_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_vec),
        .q   (sync_vec)
    );

    gf_len_sel u_len (
        .code    (flt_code),
        .en      (flt_en),
        .req_len (req_len)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gf_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .din     (sync_vec[i]),
            .req_len (req_len),
            .q       (ch_q[i])
        );
    end

    assign scl_sync = sync_vec[0];
    assign sda_sync = sync_vec[1];

    assign scl_flt  = ch_q[0].lvl;
    assign scl_rise = ch_q[0].rise;
    assign scl_fall = ch_q[0].fall;
    assign sda_flt  = ch_q[1].lvl;
    assign sda_rise = ch_q[1].rise;
    assign sda_fall = ch_q[1].fall;
endmodule

// File: rtl/i2c_gf_checker.sv
module i2c_gf_checker (
    input logic clk,
    input logic rst,
    input logic scl_sync,
    input logic sda_sync,
    input logic scl_flt,
    input logic sda_flt,
    input logic scl_rise,
    input logic scl_fall,
    input logic sda_rise,
    input logic sda_fall
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (scl_flt && sda_flt && !scl_rise && !scl_fall && !sda_rise && !sda_fall));

    a_r7_scl_fall_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_flt) == scl_fall);

    a_r7_scl_rise_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_flt) == scl_rise);

    a_r7_sda_fall_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_flt) == sda_fall);

    a_r7_sda_rise_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_flt) == sda_rise);

    a_r9_scl_follows_input: assert property (@(posedge clk) disable iff (rst)
        (scl_flt != $past(scl_flt)) |-> ($past(scl_sync) == scl_flt));

    a_r9_sda_follows_input: assert property (@(posedge clk) disable iff (rst)
        (sda_flt != $past(sda_flt)) |-> ($past(sda_sync) == sda_flt));
endmodule

bind i2c_glitch_filter i2c_gf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_sync (scl_sync),
    .sda_sync (sda_sync),
    .scl_flt  (scl_flt),
    .sda_flt  (sda_flt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_rise (sda_rise),
    .sda_fall (sda_fall)
);

// File: tb/i2c_glitch_filter_bench.sv
module i2c_glitch_filter_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_raw = 1'b1, sda_raw = 1'b1;
    logic [2:0] flt_code = 3'd0;
    logic flt_en = 1'b0;
    logic scl_flt, sda_flt, scl_rise, scl_fall, sda_rise, sda_fall;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;   // 4 ns period

    i2c_glitch_filter u_i2c_glitch_filter (
        .clk(clk), .rst(rst), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .flt_code(flt_code), .flt_en(flt_en),
        .scl_flt(scl_flt), .sda_flt(sda_flt),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_rise(sda_rise), .sda_fall(sda_fall)
    );

    // vector: {chan(1: data line), en, code[2:0], width[5:0]}
    localparam int NV = 24;
    localparam logic [10:0] VECS [NV] = '{
        {1'b0,1'b1,3'd1,6'd1},
        {1'b0,1'b1,3'd2,6'd1}, {1'b0,1'b1,3'd2,6'd2},
        {1'b0,1'b1,3'd3,6'd2}, {1'b0,1'b1,3'd3,6'd3},
        {1'b0,1'b1,3'd4,6'd3}, {1'b0,1'b1,3'd4,6'd4},
        {1'b0,1'b1,3'd5,6'd7}, {1'b0,1'b1,3'd5,6'd8},
        {1'b0,1'b1,3'd6,6'd15},{1'b0,1'b1,3'd6,6'd16},
        {1'b0,1'b1,3'd7,6'd31},{1'b0,1'b1,3'd7,6'd32},
        {1'b0,1'b1,3'd0,6'd1},
        {1'b0,1'b0,3'd7,6'd1}, {1'b0,1'b0,3'd4,6'd2},
        {1'b1,1'b1,3'd1,6'd1},
        {1'b1,1'b1,3'd3,6'd2}, {1'b1,1'b1,3'd3,6'd3},
        {1'b1,1'b1,3'd5,6'd7}, {1'b1,1'b1,3'd5,6'd8},
        {1'b1,1'b1,3'd7,6'd31},{1'b1,1'b1,3'd7,6'd32},
        {1'b1,1'b0,3'd6,6'd1}
    };

    function automatic int bench_len(input logic en, input logic [2:0] code);
        int tbl [8] = '{0, 1, 2, 3, 4, 8, 16, 32};
        int n = en ? tbl[code] : 0;
        return (n == 0) ? 1 : n;
    endfunction

    task automatic chk(input string tag, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_line(input logic ch, input logic v);
        if (ch) sda_raw = v; else scl_raw = v;
    endtask

    function automatic logic get_flt(input logic ch);
        return ch ? sda_flt : scl_flt;
    endfunction

    // low pulse of 'width' clocks on one line; measures edge index of the filtered fall
    task automatic run_pulse(input logic ch, input logic en, input logic [2:0] code,
                             input int width, input string tag);
        int first_low = -1, fall_at = -1, nfall = 0, nrise = 0, other_moves = 0;
        int n = bench_len(en, code);
        logic pass = (width >= n);
        @(negedge clk);
        flt_en = en; flt_code = code;
        repeat (3) @(negedge clk);
        set_line(ch, 1'b0);
        for (int j = 1; j <= 100; j++) begin
            @(posedge clk); @(negedge clk);
            if (j == width) set_line(ch, 1'b1);
            if (!get_flt(ch) && first_low < 0) first_low = j;
            if (ch ? sda_fall : scl_fall) begin nfall++; if (fall_at < 0) fall_at = j; end
            if (ch ? sda_rise : scl_rise) nrise++;
            if (!get_flt(!ch) || (ch ? (scl_rise | scl_fall) : (sda_rise | sda_fall)))
                other_moves++;
        end
        if (pass) begin
            chk({tag, " R4 latency"}, first_low == n + 2, first_low, n + 2);
            chk({tag, " R7 fall strobe"}, fall_at == n + 2 && nfall == 1, fall_at, n + 2);
            chk({tag, " R7 rise strobe count"}, nrise == 1, nrise, 1);
        end else begin
            chk({tag, " R3 runt rejected"}, first_low < 0 && nfall == 0 && nrise == 0,
                first_low, -1);
        end
        chk({tag, " R8 other line quiet"}, other_moves == 0, other_moves, 0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 during reset", scl_flt && sda_flt && !scl_rise && !scl_fall && !sda_rise && !sda_fall,
            {scl_flt, sda_flt}, 3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", scl_flt && sda_flt && !scl_rise && !scl_fall && !sda_rise && !sda_fall,
            {scl_flt, sda_flt}, 3);

        // table walk: R2, R3, R4, R5, R6, R7, R8
        for (int v = 0; v < NV; v++) begin
            logic [10:0] e = VECS[v];
            string t;
            t = $sformatf("vec%0d(R2 code=%0d en=%0d w=%0d ch=%0d)", v, e[8:6], e[9], e[5:0], e[10]);
            run_pulse(e[10], e[9], e[8:6], int'(e[5:0]), t);
        end

        // R3 restart: code 4, low 3, high 1, low 3
        begin
            int falls = 0;
            @(negedge clk); flt_en = 1; flt_code = 3'd4;
            repeat (3) @(negedge clk);
            for (int j = 1; j <= 40; j++) begin
                scl_raw = !(j <= 3 || (j >= 5 && j <= 7));
                @(posedge clk); @(negedge clk);
                if (scl_fall || !scl_flt) falls++;
            end
            chk("R3 count restart rejects split runt", falls == 0, falls, 0);
        end

        // R9 mid-count setting change: code 7 held low, switch to code 1 after 5 clocks
        begin
            int first_low = -1;
            @(negedge clk); flt_en = 1; flt_code = 3'd7;
            repeat (3) @(negedge clk);
            scl_raw = 0;
            for (int j = 1; j <= 60; j++) begin
                @(posedge clk); @(negedge clk);
                if (j == 5) flt_code = 3'd1;
                if (!scl_flt && first_low < 0) first_low = j;
            end
            chk("R9 pending transition keeps length", first_low == 34, first_low, 34);
            // R7 rise after long low with new length 1 now latched
            begin
                int rise_at = -1;
                scl_raw = 1;
                for (int j = 1; j <= 20; j++) begin
                    @(posedge clk); @(negedge clk);
                    if (scl_rise && rise_at < 0) rise_at = j;
                end
                chk("R7 rise strobe timing", rise_at == 3, rise_at, 3);
            end
        end

        // R9 idle setting churn produces no edge
        begin
            int moves = 0;
            for (int j = 0; j < 24; j++) begin
                @(negedge clk);
                flt_en = j[0]; flt_code = 3'(j);
                if (!scl_flt || !sda_flt || scl_rise || scl_fall || sda_rise || sda_fall) moves++;
            end
            chk("R9 idle setting change no edge", moves == 0, moves, 0);
        end

        // R1 reset reasserted mid-low
        @(negedge clk); flt_en = 0; scl_raw = 0;
        repeat (6) @(negedge clk);
        rst = 1;
        @(negedge clk);
        scl_raw = 1;
        @(negedge clk);
        chk("R1 reset restores idle", scl_flt && !scl_rise && !scl_fall, scl_flt, 1);
        rst = 0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule